// File: doc/BRIEF.md
# Dual-Lane Serial ADC Reader

This block is a serial-port master for an eight-channel simultaneous-sampling converter. The converter presents its results on two serial data lines at once. One line carries channels 1 to 4 and the other carries channels 5 to 8. The block drives the active-low select and the serial clock, and it shifts both lines in parallel. Each channel takes a 16-clock slot. The first 14 bits of a slot are the sample, sent most significant bit first. The last two bits of the slot are thrown away.

A frame starts on an edge of the converter's busy line. In normal mode the frame starts when busy falls, so the block reads after the conversion. In early mode it starts when busy rises, so the block reads while the next conversion is running. The converter drives a first-data flag. The flag must be high at the first sample point and low once the first slot is over. If either test fails, the block drops the frame and pulses an error output. After a good frame, the eight results leave on a valid-qualified stream. They come out in channel order, sign-extended to 16 bits, each with a 3-bit channel tag.

The serial clock runs at a programmable fraction of the system clock. The divider input gives the length of each clock phase in system cycles. This lets the integrator stay under the converter's maximum serial rate and its minimum pulse-width limits.

Top module: `dual_lane_adc_reader`

## Requirements
- R1: After a synchronous reset the block is in this state: `cs_n_o`=1, `sclk_o`=1, `smp_valid_o`=0 and `align_err_o`=0.
- R2: When `read_early_i`=0, a frame starts on a falling edge of busy. When `read_early_i`=1, a frame starts on a rising edge of busy. In both modes `cs_n_o` goes low after the first clock edge at which `busy_i` is sampled at its new level.
- R3: Let H be `half_div_i`, where a value of 0 counts as 1. `sclk_o` stays high while idle. The first falling edge comes H clocks after `cs_n_o` falls. After that, every high phase and every low phase lasts exactly H clocks.
- R4: A complete frame has exactly 64 falling edges of `sclk_o`. After the last one, `cs_n_o` returns high with `sclk_o` high. `sclk_o` is never low while `cs_n_o` is high.
- R5: Both lanes are sampled at each falling edge of `sclk_o`. In every slot of 16 falling edges, the first 14 samples are data bits 13 down to 0. Samples 15 and 16 of each slot are ignored.
- R6: After a good frame, eight samples leave on consecutive cycles with tags 0 to 7. Tags 0 to 3 hold lane A slots 0 to 3, which are channels 1 to 4. Tags 4 to 7 hold lane B slots 0 to 3, which are channels 5 to 8.
- R7: Each 14-bit two's-complement sample is output with bit 13 copied into bits 15 and 14.
- R8: If the first-data flag is low at the first falling edge, the frame is dropped. `align_err_o` pulses for one cycle, `cs_n_o` returns high and no samples are emitted.
- R9: If the first-data flag is still high at the 17th falling edge, which is the first sample of slot 1, the frame is dropped in the same way as in R8.
- R10: Edges on busy while `cs_n_o` is low have no effect: the running frame stays 64 edges long and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div_i | input | DIV_W | Length of each serial clock phase in system clocks (0 counts as 1) |
| read_early_i | input | 1 | 1: start on busy rising (read during conversion); 0: start on busy falling |
| busy_i | input | 1 | Conversion-in-progress flag from the converter |
| sdo_a_i | input | 1 | Serial data lane A (channels 1 to 4) |
| sdo_b_i | input | 1 | Serial data lane B (channels 5 to 8) |
| first_flag_i | input | 1 | First-data flag from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| align_err_o | output | 1 | One-cycle pulse when a frame is dropped for misalignment |
| smp_valid_o | output | 1 | Sample stream valid |
| smp_data_o | output | OUT_W | Sign-extended sample |
| smp_tag_o | output | TAG_W | Channel tag, 0 for channel 1 through 7 for channel 8 |

## Verification
The bench models the converter at its pins and goes after five corner cases:
- **Divider value 0.** A design that reads 0 literally would stall or wrap the serial clock.
- **Minimum divider value.** At this setting a design could sample on the wrong edge and shift every word by one bit.
- **Slot padding.** The two trailing bits of each slot are driven to 1, so a design that keeps them would corrupt the low bits or the sign.
- **Alignment flag at both check points.** The flag is held low at the start of one frame and left stuck high in another. A design that checks only one point would emit garbage for the other case.
- **Mid-frame busy edges, in both modes.** A design that re-triggers on them would restart the frame or run a second one.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  typedef enum logic {ST_IDLE, ST_SHIFT} rd_state_t;

  function automatic int unsigned dlr_log2(input int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/dlr_sclk_div.sv
module dlr_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_eff;
  logic             wrap;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign wrap     = (cnt >= half_eff - DIV_W'(1));
  assign fall_o   = run_i && wrap && sclk_o;
  assign rise_o   = run_i && wrap && !sclk_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sclk_o <= 1'b1;
    end else if (!run_i || stop_i) begin
      cnt    <= '0;
      sclk_o <= 1'b1;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/dlr_lane.sv
module dlr_lane #(
  parameter int DATA_W    = 14,
  parameter int SLOT_BITS = 16,
  parameter int SLOTS     = 4,
  localparam int POS_W    = $clog2(SLOT_BITS),
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         take_i,
  input  logic                         din_i,
  input  logic [POS_W-1:0]             pos_i,
  input  logic [SLOT_W-1:0]            slot_i,
  output logic [SLOTS-1:0][DATA_W-1:0] words_o
);
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_nxt;

  assign sh_nxt = {sh[DATA_W-2:0], din_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (take_i && (pos_i < POS_W'(DATA_W))) begin
      sh <= sh_nxt;
    end
  end

  // Result store carries no reset so it maps onto plain storage.
  always_ff @(posedge clk) begin
    if (take_i && (pos_i == POS_W'(DATA_W - 1))) begin
      words_o[slot_i] <= sh_nxt;
    end
  end
endmodule

// File: rtl/dlr_emit.sv
module dlr_emit #(
  parameter int DATA_W  = 14,
  parameter int OUT_W   = 16,
  parameter int LANE_CH = 4,
  localparam int NCH    = 2 * LANE_CH,
  localparam int TAG_W  = $clog2(NCH)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic [LANE_CH-1:0][DATA_W-1:0] words_a_i,
  input  logic [LANE_CH-1:0][DATA_W-1:0] words_b_i,
  output logic                           valid_o,
  output logic [OUT_W-1:0]               data_o,
  output logic [TAG_W-1:0]               tag_o
);
  logic              active;
  logic [TAG_W-1:0]  idx;
  logic [DATA_W-1:0] word;

  always_comb begin
    if (idx[TAG_W-1]) word = words_b_i[idx[TAG_W-2:0]];
    else              word = words_a_i[idx[TAG_W-2:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= active;
      if (active) begin
        data_o <= {{(OUT_W-DATA_W){word[DATA_W-1]}}, word};
        tag_o  <= idx;
        idx    <= idx + TAG_W'(1);
        if (idx == TAG_W'(NCH - 1)) active <= 1'b0;
      end
      if (start_i) begin
        active <= 1'b1;
        idx    <= '0;
      end
    end
  end

  // R6: tags climb by one on back-to-back cycles until the last channel
  assert_tag_step_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o && (tag_o != TAG_W'(NCH - 1)) |=> valid_o && (tag_o == $past(tag_o) + TAG_W'(1)));

  // R6: every burst opens with channel tag 0
  assert_burst_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> (tag_o == '0));
endmodule

// File: rtl/dual_lane_adc_reader.sv
module dual_lane_adc_reader
  import dlr_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int OUT_W     = 16,
  parameter int SLOT_BITS = 16,
  parameter int LANE_CH   = 4,
  parameter int DIV_W     = 8,
  localparam int TAG_W    = $clog2(2 * LANE_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             read_early_i,
  input  logic             busy_i,
  input  logic             sdo_a_i,
  input  logic             sdo_b_i,
  input  logic             first_flag_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             align_err_o,
  output logic             smp_valid_o,
  output logic [OUT_W-1:0] smp_data_o,
  output logic [TAG_W-1:0] smp_tag_o
);
  localparam int FRAME_FALLS = LANE_CH * SLOT_BITS;
  localparam int CNT_W       = $clog2(FRAME_FALLS + 1);
  localparam int POS_W       = $clog2(SLOT_BITS);
  localparam int SLOT_W      = $clog2(LANE_CH);

  rd_state_t        state;
  logic             busy_q, cs_n_q, done_q, err_q;
  logic [CNT_W-1:0] nedge;
  logic             trig, fall, rise, flag_bad, frame_end, take;
  logic             lane_din [2];
  logic [1:0][LANE_CH-1:0][DATA_W-1:0] lane_words;

  assign trig = (state == ST_IDLE) &&
                (read_early_i ? (busy_i && !busy_q) : (!busy_i && busy_q));
  assign flag_bad  = fall && (((nedge == '0) && !first_flag_i) ||
                              ((nedge == CNT_W'(SLOT_BITS)) && first_flag_i));
  assign frame_end = rise && (nedge == CNT_W'(FRAME_FALLS));
  assign take      = fall && !flag_bad;

  dlr_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst),
    .run_i(state == ST_SHIFT), .stop_i(flag_bad || frame_end),
    .half_i(half_div_i), .sclk_o(sclk_o), .fall_o(fall), .rise_o(rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy_q <= 1'b0;
      cs_n_q <= 1'b1;
      nedge  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: if (trig) begin
          state  <= ST_SHIFT;
          cs_n_q <= 1'b0;
          nedge  <= '0;
        end
        ST_SHIFT: begin
          if (flag_bad) begin
            state  <= ST_IDLE;
            cs_n_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (frame_end) begin
            state  <= ST_IDLE;
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
          end else if (fall) begin
            nedge <= nedge + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign lane_din[0] = sdo_a_i;
  assign lane_din[1] = sdo_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dlr_lane #(.DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS), .SLOTS(LANE_CH)) u_lane (
      .clk(clk), .rst(rst), .take_i(take), .din_i(lane_din[g]),
      .pos_i(nedge[POS_W-1:0]), .slot_i(nedge[POS_W +: SLOT_W]),
      .words_o(lane_words[g])
    );
  end

  dlr_emit #(.DATA_W(DATA_W), .OUT_W(OUT_W), .LANE_CH(LANE_CH)) u_emit (
    .clk(clk), .rst(rst), .start_i(done_q),
    .words_a_i(lane_words[0]), .words_b_i(lane_words[1]),
    .valid_o(smp_valid_o), .data_o(smp_data_o), .tag_o(smp_tag_o)
  );

  assign cs_n_o      = cs_n_q;
  assign align_err_o = err_q;

  // R4: the serial clock rests high whenever select is released
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> sclk_o);

  // R4, R8: select is released only at a frame end or a drop
  assert_cs_release_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q) |-> (done_q || err_q));

  // R4: a completed frame has seen every falling edge
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (nedge == CNT_W'(FRAME_FALLS)));

  // R8: a dropped frame leaves select released
  assert_drop_release_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> cs_n_q);
endmodule

// File: tb/dual_lane_adc_reader_test.sv
`timescale 1ns/1ps
module dual_lane_adc_reader_test;
  localparam int DW = 14, OW = 16, SB = 16, LC = 4, DVW = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic [DVW-1:0] half_div = 8'd2;
  logic read_early = 1'b0, busy = 1'b0, sdo_a = 1'b0, sdo_b = 1'b0, fflag = 1'b0;
  logic cs_n, sclk, align_err, smp_valid;
  logic [OW-1:0] smp_data;
  logic [2:0] smp_tag;

  dual_lane_adc_reader uut (
    .clk(clk), .rst(rst), .half_div_i(half_div), .read_early_i(read_early),
    .busy_i(busy), .sdo_a_i(sdo_a), .sdo_b_i(sdo_b), .first_flag_i(fflag),
    .cs_n_o(cs_n), .sclk_o(sclk), .align_err_o(align_err),
    .smp_valid_o(smp_valid), .smp_data_o(smp_data), .smp_tag_o(smp_tag)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [DW-1:0] wa [LC];
  logic [DW-1:0] wb [LC];
  int bc = 0, falls = 0, runlen = 0;
  int hi_min, hi_max, lo_min, lo_max, nsmp, nerr;
  bit bad_first = 0, stuck_flag = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1;
  logic [OW-1:0] got_d [16];
  logic [2:0]    got_t [16];

  function automatic logic [OW-1:0] sx(input logic [DW-1:0] w);
    return {{(OW-DW){w[DW-1]}}, w};
  endfunction

  // Converter pin model and output monitor, all away from the active edge
  always @(negedge clk) begin
    if (smp_valid) begin
      if (nsmp < 16) begin got_d[nsmp] = smp_data; got_t[nsmp] = smp_tag; end
      nsmp++;
    end
    if (align_err) nerr++;
    if (!cs_n) begin
      if (p_cs) begin
        bc = 0; falls = 0; fflag = !bad_first; runlen = 1;
      end else if (sclk != p_sclk) begin
        if (p_sclk) begin
          if (runlen < hi_min) hi_min = runlen;
          if (runlen > hi_max) hi_max = runlen;
          falls++;
          if (falls == SB && !stuck_flag) fflag = 1'b0;
        end else begin
          if (runlen < lo_min) lo_min = runlen;
          if (runlen > lo_max) lo_max = runlen;
          bc++;
        end
        runlen = 1;
      end else begin
        runlen++;
      end
      if (bc / SB < LC) begin
        sdo_a = ((bc % SB) < DW) ? wa[bc / SB][DW - 1 - (bc % SB)] : 1'b1;
        sdo_b = ((bc % SB) < DW) ? wb[bc / SB][DW - 1 - (bc % SB)] : 1'b1;
      end
    end else begin
      fflag = 1'b0;
    end
    p_cs = cs_n;
    p_sclk = sclk;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int half, input bit early, input bit badf,
                           input bit stuck, input int kind, input bit toggle);
    int h, t;
    h = (half == 0) ? 1 : half;
    for (int i = 0; i < LC; i++) begin
      case (kind)
        1: begin wa[i] = 14'h2000; wb[i] = 14'h2000 | 14'(i); end
        2: begin wa[i] = 14'h1FFF; wb[i] = 14'h1FFF - 14'(i); end
        default: begin wa[i] = 14'($urandom); wb[i] = 14'($urandom); end
      endcase
    end
    @(negedge clk);
    bad_first = badf; stuck_flag = stuck; half_div = 8'(half); read_early = early;
    nsmp = 0; nerr = 0; hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
    @(negedge clk) busy = 1'b1;
    if (!early) begin
      @(negedge clk); @(negedge clk);
      busy = 1'b0;
    end
    #0 chk("R2", "cs_n before sampling edge", cs_n, 1);
    @(negedge clk);
    chk("R2", "cs_n after trigger edge", cs_n, 0);
    if (toggle) begin
      repeat (20) @(negedge clk);
      busy = ~busy;
      @(negedge clk) busy = ~busy;
      @(negedge clk) busy = ~busy;
      @(negedge clk) busy = ~busy;
    end
    t = 0;
    while (!cs_n && t < 5000) begin @(negedge clk); t++; end
    busy = 1'b0;
    repeat (14) @(negedge clk);
    chk("R4", "sclk high after frame", sclk, 1);
    if (badf || stuck) begin
      chk(badf ? "R8" : "R9", "error pulses", nerr, 1);
      chk(badf ? "R8" : "R9", "samples from dropped frame", nsmp, 0);
      chk(badf ? "R8" : "R9", "falls before drop", falls, badf ? 0 : SB);
    end else begin
      chk("R4", "falling edges in frame", falls, LC * SB);
      chk("R8", "no error on good frame", nerr, 0);
      chk("R6", "sample count", nsmp, 2 * LC);
      for (int i = 0; i < 2 * LC && i < nsmp; i++) begin
        chk("R6", "channel tag", got_t[i], i);
        chk("R5 R7", "sample value", got_d[i], sx(i < LC ? wa[i] : wb[i - LC]));
      end
      chk("R3", "min high phase", hi_min, h);
      chk("R3", "max high phase", hi_max, h);
      chk("R3", "min low phase", lo_min, h);
      chk("R3", "max low phase", lo_max, h);
    end
    if (toggle) begin
      repeat (20) @(negedge clk);
      chk("R10", "no second frame after mid-frame busy edges", cs_n, 1);
      chk("R10", "no extra samples", nsmp, (badf || stuck) ? 0 : 2 * LC);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "cs_n at reset", cs_n, 1);
    chk("R1", "sclk at reset", sclk, 1);
    chk("R1", "valid at reset", smp_valid, 0);
    chk("R1", "align_err at reset", align_err, 0);
    run_frame(2, 0, 0, 0, 0, 0);
    run_frame(0, 0, 0, 0, 0, 0);
    run_frame(1, 0, 0, 0, 1, 0);
    run_frame(3, 1, 0, 0, 2, 0);
    run_frame(2, 0, 1, 0, 0, 0);
    run_frame(2, 0, 0, 1, 0, 0);
    run_frame(2, 0, 0, 0, 0, 1);
    run_frame(1, 1, 0, 0, 0, 1);
    run_frame(2, 1, 1, 0, 0, 0);
    for (int n = 0; n < 14; n++) begin
      int r;
      r = int'($urandom % 10);
      run_frame(int'($urandom % 5), 1'($urandom), r == 0, r == 1,
                int'($urandom % 3), 1'($urandom));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule